// File: doc/BRIEF.md
# Integer Pipeline Operand Bypass Selector

This block decides, for every source operand of the instruction in decode, whether the value should come from an older instruction that is still in flight instead of from the register file. It looks at the execute and memory stages of an in-order integer pipeline. Each stage supplies a valid bit, a bit saying the instruction will write an integer destination, the destination address and a candidate result. The memory stage also supplies a bit marking a memory access. The load data returned by the data cache arrives on its own input.

Each operand address is compared against a fixed, prioritised list of four producers. The first matching entry in the list wins. Entry 0 is a permanent match for register zero and supplies the value zero. Entry 1 is the execute-stage result. Entry 2 is the memory-stage result of an instruction that is not a memory access, taken from the writeback data register. Entry 3 is the memory-stage instruction of any kind, with its data taken from the data-cache return path. When nothing matches, the register-file read data passes through.

For every operand the block gives the chosen value, a one-hot select, an encoded select and a flag telling whether a bypass was used. The selection is combinational. A parameter can add one register stage on the outputs for timing.

Top module: `operand_bypass_net`

## Requirements
- R1: An operand whose address is 0 always takes entry 0. The value is 0, the bypass flag is 1 and the encoded select is 0. Producers in flight that name register 0 as their destination do not change this.
- R2: For a nonzero address, if the execute stage has valid=1, writes-destination=1 and a destination equal to the address, the operand takes the execute data with encoded select 1.
- R3: If the execute stage does not match, and the memory stage has valid=1, writes-destination=1, memory-access=0 and a matching destination, the operand takes the memory-stage data with encoded select 2.
- R4: If the execute stage does not match, and the memory stage has valid=1, writes-destination=1, memory-access=1 and a matching destination, the operand takes the data-cache return value with encoded select 3.
- R5: When the execute and memory stages both match the same address, the execute stage wins.
- R6: A stage whose valid bit or writes-destination bit is 0 never matches, whatever its destination address is.
- R7: When no entry matches, the operand takes the register-file data. The bypass flag, the one-hot select and the encoded select are then all 0.
- R8: The one-hot select has bit i set exactly when entry i is chosen. Bit 0 is register zero, bit 1 is execute, bit 2 is the memory-stage ALU result and bit 3 is the memory-stage load. Its set bit equals the encoded select.
- R9: Every operand is resolved independently from its own address and its own register-file data.
- R10: With the output register enabled, each output equals the combinational result of the previous clock edge. A synchronous active-low reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used by the optional output register) |
| rst_n | input | 1 | Synchronous active-low reset |
| ex_valid | input | 1 | Execute stage holds a valid instruction |
| ex_wr_dst | input | 1 | Execute-stage instruction writes an integer destination |
| ex_dst | input | AW | Execute-stage destination address |
| ex_result | input | DW | Execute result latched for the memory stage |
| mem_valid | input | 1 | Memory stage holds a valid instruction |
| mem_wr_dst | input | 1 | Memory-stage instruction writes an integer destination |
| mem_is_access | input | 1 | Memory-stage instruction is a memory access |
| mem_dst | input | AW | Memory-stage destination address |
| mem_result | input | DW | Memory-stage result latched for writeback |
| dcache_data | input | DW | Data-cache load return value |
| src_addr | input | NOPS*AW | Source addresses, operand k at bits [k*AW +: AW] |
| rf_rdata | input | NOPS*DW | Register-file read data per operand |
| opnd_data | output | NOPS*DW | Selected operand values |
| opnd_sel_oh | output | NOPS*4 | One-hot select per operand |
| opnd_sel_idx | output | NOPS*2 | Encoded select per operand |
| opnd_fwd | output | NOPS | Bypass-used flag per operand |

## Verification
On every cycle, the assertions check several relations on each operand's combinational result. Register zero reads as zero. A matching execute stage supplies its data. A matching memory-stage instruction supplies ALU data or cache data depending on its access bit. A miss passes the register-file data through. The select is one-hot or zero and agrees with the encoded index. The optional register also delays its input by exactly one cycle. Only the bench's near-exhaustive sweep over all flag, address and operand combinations, compared against an independent priority scan, can show these things: that every combination resolves to the right entry, that disqualified stages are ignored, and that the two operands do not interfere.

// File: rtl/bypass_pkg.sv
// Shared definitions for the operand bypass selector.
// Assumes a fixed four-entry producer list; entry order is the priority.
package bypass_pkg;

    localparam int BYP_NSRC = 4;

    typedef enum logic [1:0] {
        BYP_ZERO     = 2'd0,
        BYP_EX       = 2'd1,
        BYP_MEM_ALU  = 2'd2,
        BYP_MEM_LOAD = 2'd3
    } byp_src_e;

endpackage

// File: rtl/fwd_match.sv
// Producer match for one operand: builds the hit vector over the four
// bypass entries. Assumes stage flags are already qualified by the caller.
module fwd_match
    import bypass_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0]       src,
    input  logic                ex_valid,
    input  logic                ex_wr_dst,
    input  logic [AW-1:0]       ex_dst,
    input  logic                mem_valid,
    input  logic                mem_wr_dst,
    input  logic                mem_is_access,
    input  logic [AW-1:0]       mem_dst,
    output logic [BYP_NSRC-1:0] hit
);

    // Compare the operand address against each producer entry.
    always_comb begin
        hit                = '0;
        hit[BYP_ZERO]      = (src == '0);
        hit[BYP_EX]        = ex_valid && ex_wr_dst && (ex_dst == src);
        hit[BYP_MEM_ALU]   = mem_valid && mem_wr_dst && !mem_is_access && (mem_dst == src);
        hit[BYP_MEM_LOAD]  = mem_valid && mem_wr_dst && (mem_dst == src);
    end

endmodule

// File: rtl/fwd_prio_mux.sv
// Priority select for one operand: the lowest-index hit wins; a miss passes
// the register-file data. Assumes candidate data is aligned to entry index.
module fwd_prio_mux
    import bypass_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [BYP_NSRC-1:0]         hit,
    input  logic [BYP_NSRC-1:0][DW-1:0] cand,
    input  logic [DW-1:0]               rf_data,
    output logic [DW-1:0]               data,
    output logic [BYP_NSRC-1:0]         sel_oh,
    output byp_src_e                    sel_idx,
    output logic                        any_hit
);

    // Scan from the last entry down so the first entry has the final word.
    always_comb begin
        data    = rf_data;
        sel_oh  = '0;
        sel_idx = BYP_ZERO;
        any_hit = 1'b0;
        for (int i = BYP_NSRC - 1; i >= 0; i--) begin
            if (hit[i]) begin
                data    = cand[i];
                sel_oh  = '0;
                sel_oh[i] = 1'b1;
                sel_idx = byp_src_e'(2'(i));
                any_hit = 1'b1;
            end
        end
    end

    // R8: select is one-hot or empty
    a_r8_sel_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_oh));

    // R8: the set select bit agrees with the encoded index
    a_r8_idx_agrees: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> sel_oh[sel_idx] && hit[sel_idx]);

    // R7: with no hit the register-file data passes through
    a_r7_miss_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (hit == '0) |-> (data == rf_data) && (sel_oh == '0) && !any_hit);

endmodule

// File: rtl/fwd_out_stage.sv
// Optional output register. REG=1 adds one flop stage with a synchronous
// active-low clear; REG=0 is a wire. Assumes W covers all packed outputs.
module fwd_out_stage #(
    parameter int W   = 8,
    parameter bit REG = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (REG) begin : g_reg
            // Capture the combinational result, clearing on reset.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '0;
                else        q <= d;
            end

            // R10: the output lags its input by exactly one cycle
            a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (q == $past(d)));
        end else begin : g_wire
            wire unused_clk_rst = ^{clk, rst_n};
            // Pass the result straight through.
            always_comb q = d;
        end
    endgenerate

endmodule

// File: rtl/operand_bypass_net.sv
// Operand bypass selector for an in-order integer pipeline. For each of
// NOPS source operands it picks among register zero, the execute result,
// the memory-stage ALU result and the data-cache return, falling back to
// register-file data. Assumes stage flags come straight from the pipeline.
module operand_bypass_net
    import bypass_pkg::*;
#(
    parameter int DW      = 64,
    parameter int AW      = 5,
    parameter int NOPS    = 2,
    parameter bit OUT_REG = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ex_valid,
    input  logic                 ex_wr_dst,
    input  logic [AW-1:0]        ex_dst,
    input  logic [DW-1:0]        ex_result,
    input  logic                 mem_valid,
    input  logic                 mem_wr_dst,
    input  logic                 mem_is_access,
    input  logic [AW-1:0]        mem_dst,
    input  logic [DW-1:0]        mem_result,
    input  logic [DW-1:0]        dcache_data,
    input  logic [NOPS*AW-1:0]   src_addr,
    input  logic [NOPS*DW-1:0]   rf_rdata,
    output logic [NOPS*DW-1:0]   opnd_data,
    output logic [NOPS*4-1:0]    opnd_sel_oh,
    output logic [NOPS*2-1:0]    opnd_sel_idx,
    output logic [NOPS-1:0]      opnd_fwd
);

    localparam int SLOT_W = DW + BYP_NSRC + 2 + 1;
    localparam int PACK_W = NOPS * SLOT_W;

    logic [BYP_NSRC-1:0][DW-1:0] cand;
    logic [PACK_W-1:0]           comb_pack;
    logic [PACK_W-1:0]           out_pack;

    // Candidate data in entry order.
    always_comb begin
        cand[BYP_ZERO]     = '0;
        cand[BYP_EX]       = ex_result;
        cand[BYP_MEM_ALU]  = mem_result;
        cand[BYP_MEM_LOAD] = dcache_data;
    end

    generate
        for (genvar k = 0; k < NOPS; k++) begin : g_op
            logic [AW-1:0]       src;
            logic [BYP_NSRC-1:0] hit;
            logic [DW-1:0]       c_data;
            logic [BYP_NSRC-1:0] c_oh;
            byp_src_e            c_idx;
            logic                c_any;

            assign src = src_addr[k*AW +: AW];

            fwd_match #(.AW(AW)) i_match (
                .src           (src),
                .ex_valid      (ex_valid),
                .ex_wr_dst     (ex_wr_dst),
                .ex_dst        (ex_dst),
                .mem_valid     (mem_valid),
                .mem_wr_dst    (mem_wr_dst),
                .mem_is_access (mem_is_access),
                .mem_dst       (mem_dst),
                .hit           (hit)
            );

            fwd_prio_mux #(.DW(DW)) i_mux (
                .clk     (clk),
                .rst_n   (rst_n),
                .hit     (hit),
                .cand    (cand),
                .rf_data (rf_rdata[k*DW +: DW]),
                .data    (c_data),
                .sel_oh  (c_oh),
                .sel_idx (c_idx),
                .any_hit (c_any)
            );

            // Pack this operand's result for the output stage.
            always_comb comb_pack[k*SLOT_W +: SLOT_W] = {c_any, c_idx, c_oh, c_data};

            // Unpack the (possibly registered) result onto the ports.
            always_comb begin
                {opnd_fwd[k], opnd_sel_idx[k*2 +: 2], opnd_sel_oh[k*4 +: 4],
                 opnd_data[k*DW +: DW]} = out_pack[k*SLOT_W +: SLOT_W];
            end

            // R1: register zero reads as zero through entry 0
            a_r1_zero_src: assert property (@(posedge clk) disable iff (!rst_n)
                (src == '0) |-> (c_data == '0) && c_any && (c_idx == BYP_ZERO));

            // R2: a qualified execute producer supplies the execute result
            a_r2_ex_wins: assert property (@(posedge clk) disable iff (!rst_n)
                (src != '0 && ex_valid && ex_wr_dst && ex_dst == src)
                |-> (c_data == ex_result) && (c_idx == BYP_EX));

            // R3: memory-stage non-access result comes from the writeback register
            a_r3_mem_alu: assert property (@(posedge clk) disable iff (!rst_n)
                (src != '0 && !(ex_valid && ex_wr_dst && ex_dst == src) &&
                 mem_valid && mem_wr_dst && !mem_is_access && mem_dst == src)
                |-> (c_data == mem_result) && (c_idx == BYP_MEM_ALU));

            // R4: memory-stage access result comes from the data-cache path
            a_r4_mem_load: assert property (@(posedge clk) disable iff (!rst_n)
                (src != '0 && !(ex_valid && ex_wr_dst && ex_dst == src) &&
                 mem_valid && mem_wr_dst && mem_is_access && mem_dst == src)
                |-> (c_data == dcache_data) && (c_idx == BYP_MEM_LOAD));

            // R6: unqualified stages give a miss for a nonzero address
            a_r6_unqualified_miss: assert property (@(posedge clk) disable iff (!rst_n)
                (src != '0 && !(ex_valid && ex_wr_dst) && !(mem_valid && mem_wr_dst))
                |-> !c_any && (c_data == rf_rdata[k*DW +: DW]));
        end
    endgenerate

    fwd_out_stage #(.W(PACK_W), .REG(OUT_REG)) i_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (comb_pack),
        .q     (out_pack)
    );

endmodule

// File: tb/test_operand_bypass_net.sv
`timescale 1ns/1ps
// Near-exhaustive sweep of a small configuration (3-bit addresses, 16-bit
// data) against an independent priority scan; a second instance checks the
// registered-output variant one cycle later.
module test_operand_bypass_net;

    localparam int DW = 16;
    localparam int AW = 3;
    localparam int NOPS = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ex_valid = 0, ex_wr_dst = 0, mem_valid = 0, mem_wr_dst = 0, mem_is_access = 0;
    logic [AW-1:0] ex_dst = '0, mem_dst = '0;
    logic [DW-1:0] ex_result = '0, mem_result = '0, dcache_data = '0;
    logic [NOPS*AW-1:0] src_addr = '0;
    logic [NOPS*DW-1:0] rf_rdata = '0;

    logic [NOPS*DW-1:0] c_data, r_data;
    logic [NOPS*4-1:0]  c_oh, r_oh;
    logic [NOPS*2-1:0]  c_idx, r_idx;
    logic [NOPS-1:0]    c_fwd, r_fwd;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    operand_bypass_net #(.DW(DW), .AW(AW), .NOPS(NOPS), .OUT_REG(1'b0)) i_operand_bypass_net (
        .clk(clk), .rst_n(rst_n),
        .ex_valid(ex_valid), .ex_wr_dst(ex_wr_dst), .ex_dst(ex_dst), .ex_result(ex_result),
        .mem_valid(mem_valid), .mem_wr_dst(mem_wr_dst), .mem_is_access(mem_is_access),
        .mem_dst(mem_dst), .mem_result(mem_result), .dcache_data(dcache_data),
        .src_addr(src_addr), .rf_rdata(rf_rdata),
        .opnd_data(c_data), .opnd_sel_oh(c_oh), .opnd_sel_idx(c_idx), .opnd_fwd(c_fwd)
    );

    operand_bypass_net #(.DW(DW), .AW(AW), .NOPS(NOPS), .OUT_REG(1'b1)) i_operand_bypass_net_reg (
        .clk(clk), .rst_n(rst_n),
        .ex_valid(ex_valid), .ex_wr_dst(ex_wr_dst), .ex_dst(ex_dst), .ex_result(ex_result),
        .mem_valid(mem_valid), .mem_wr_dst(mem_wr_dst), .mem_is_access(mem_is_access),
        .mem_dst(mem_dst), .mem_result(mem_result), .dcache_data(dcache_data),
        .src_addr(src_addr), .rf_rdata(rf_rdata),
        .opnd_data(r_data), .opnd_sel_oh(r_oh), .opnd_sel_idx(r_idx), .opnd_fwd(r_fwd)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cycles);
            finish_run();
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference priority scan computed from the requirements.
    task automatic ref_model(input logic [AW-1:0] s, input logic [DW-1:0] rf,
                             output logic [DW-1:0] d, output logic [1:0] idx,
                             output logic any, output string req);
        if (s == 0) begin
            d = '0; idx = 2'd0; any = 1; req = "R1";
        end else if (ex_valid && ex_wr_dst && ex_dst == s) begin
            d = ex_result; idx = 2'd1; any = 1;
            req = (mem_valid && mem_wr_dst && mem_dst == s) ? "R5" : "R2";
        end else if (mem_valid && mem_wr_dst && !mem_is_access && mem_dst == s) begin
            d = mem_result; idx = 2'd2; any = 1; req = "R3";
        end else if (mem_valid && mem_wr_dst && mem_dst == s) begin
            d = dcache_data; idx = 2'd3; any = 1; req = "R4";
        end else begin
            d = rf; idx = 2'd0; any = 0; req = "R6 R7";
        end
    endtask

    initial begin
        logic [NOPS*DW-1:0] e_data;
        logic [NOPS*2-1:0]  e_idx;
        logic [NOPS*4-1:0]  e_oh;
        logic [NOPS-1:0]    e_fwd;

        // Reset state of the registered variant (R10).
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset data", 32'(r_data), 32'd0);
        check("R10 reset flags", {24'd0, r_oh}, 32'd0);
        check("R10 reset fwd", {28'd0, r_idx, r_fwd}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int fl = 0; fl < 32; fl++) begin
            for (int ed = 0; ed < 8; ed++) begin
                for (int md = 0; md < 8; md++) begin
                    for (int s0 = 0; s0 < 8; s0++) begin
                        @(negedge clk);
                        {ex_valid, ex_wr_dst, mem_valid, mem_wr_dst, mem_is_access} = 5'(fl);
                        ex_dst      = AW'(ed);
                        mem_dst     = AW'(md);
                        ex_result   = 16'hE000 | 16'(fl * 64 + ed * 8 + s0);
                        mem_result  = 16'hA000 | 16'(md * 16 + s0);
                        dcache_data = 16'hC000 | 16'(fl * 8 + md);
                        src_addr    = {AW'((s0 + ed + 3) % 8), AW'(s0)};
                        rf_rdata    = {16'h2200 | 16'(s0 * 5 + md), 16'h1100 | 16'(s0 + ed * 3)};
                        #1;
                        for (int k = 0; k < NOPS; k++) begin
                            logic [DW-1:0] d;
                            logic [1:0] idx;
                            logic any;
                            string req;
                            ref_model(src_addr[k*AW +: AW], rf_rdata[k*DW +: DW], d, idx, any, req);
                            if (k == 1) req = {req, " R9"};
                            e_data[k*DW +: DW] = d;
                            e_idx[k*2 +: 2]    = idx;
                            e_fwd[k]           = any;
                            e_oh[k*4 +: 4]     = any ? (4'b0001 << idx) : 4'b0000;
                            check({req, " data"}, 32'(c_data[k*DW +: DW]), 32'(d));
                            check({req, " idx/fwd"}, {29'd0, c_idx[k*2 +: 2], c_fwd[k]}, {29'd0, idx, any});
                            check("R8 one-hot", 32'(c_oh[k*4 +: 4]), 32'(e_oh[k*4 +: 4]));
                        end
                        @(posedge clk);
                        #1;
                        check("R10 reg data", 32'(r_data), 32'(e_data));
                        check("R10 reg sel", {20'd0, r_oh, r_idx, r_fwd}, {20'd0, e_oh, e_idx, e_fwd});
                    end
                end
            end
        end

        // Synchronous reset clears the registered outputs again (R10).
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R10 re-reset", {20'd0, r_oh, r_idx, r_fwd}, 32'd0);
        check("R10 re-reset data", 32'(r_data), 32'd0);
        finish_run();
    end

endmodule